// File: doc/BRIEF.md
# Internal Data Memory Access Router

This block sits between a CPU's data path and its data storage. Each request carries an address, an access kind (direct, indirect or MOVX-type), read and write strobes and write data. The router sends the request to one of five targets: a 128-byte lower RAM, a 128-byte upper RAM, a special-function-register (SFR) port, a 768-byte expanded RAM, or an external data bus. The three RAM arrays live inside the block. SFR contents sit in a register file outside it, and external memory is reached through a simple request/valid bus.

Byte addresses 80H to FFH lead to two separate stores. A direct access there goes to the SFR port. An indirect access there goes to the upper RAM. MOVX-type accesses below 300H go to the expanded RAM when the external-RAM select input is low. All other MOVX accesses leave the block on the external bus, which can address 64 kB. A registered one-hot chip-select output shows which target each access reached.

Top module: `dmem_router`

## Requirements
- R1: Direct and indirect accesses with byte address 00H–7FH reach one lower RAM. A value written with one kind is read back with the other. The chip select is 5'b00001.
- R2: Indirect accesses with byte address 80H–FFH reach the upper RAM, including both ends of that range. The chip select is 5'b00010.
- R3: Direct accesses with byte address 80H–FFH drive the SFR port in the same cycle. The port carries sfr_rd or sfr_wr, sfr_addr equal to the byte address, and sfr_wdata. A direct read returns the sfr_rdata sampled on that edge. The upper RAM is never written by such an access. The chip select is 5'b00100.
- R4: With extram_sel = 0, MOVX accesses with address 000H–2FFH reach the expanded RAM. This RAM is separate from the lower RAM. The chip select is 5'b01000.
- R5: A MOVX access with address 300H or higher, or any MOVX access with extram_sel = 1, raises ext_req for exactly one cycle, in the cycle after the request. During that cycle ext_addr, ext_we and ext_wdata hold the request's values. The chip select is 5'b10000, and no internal RAM changes.
- R6: After an external read, the first cycle with ext_vld high returns ext_rdata on rdata, with rdata_vld high, in the following cycle. ext_vld is ignored when no external read is pending.
- R7: Reads from the internal arrays and the SFR port give rdata_vld high with the data in the cycle after the request. Writes never raise rdata_vld.
- R8: cs is registered and one-hot: bit 0 lower, bit 1 upper, bit 2 SFR, bit 3 expanded, bit 4 external. It is all zero after an idle cycle, and after a request with the reserved kind 2'b11, which changes no storage.
- R9: When rd_en and wr_en are both high, the access is a write only.
- R10: While rst is high, rdata_vld, cs and ext_req are zero.
- R11: Direct and indirect accesses use only addr[7:0]. The higher address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | 0 direct, 1 indirect, 2 MOVX, 3 reserved |
| addr | input | 16 | Access address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| extram_sel | input | 1 | 1 sends all MOVX accesses to the external bus |
| rdata | output | 8 | Read data |
| rdata_vld | output | 1 | Read data valid |
| cs | output | 5 | Registered one-hot target of the previous access |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data |
| ext_req | output | 1 | External request pulse |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_rdata | input | 8 | External read data |
| ext_vld | input | 1 | External read data valid |

## Verification
The hardest case to reach from the ports is one address landing in two physically separate stores. The stimulus seeds the upper RAM at 90H through an indirect write, then sends a direct write to 90H. It checks that the SFR port saw that write and that an indirect read still returns the seeded byte. It does the same for the expanded RAM: a MOVX write with extram_sel high must leave on the external bus, and the expanded-RAM byte it would otherwise have hit must keep its earlier value. A stray ext_vld pulse is sent with no read outstanding, to show that rdata_vld stays low.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;
  localparam int NUM_TGT = 5;

  localparam logic [1:0] KIND_DIR  = 2'd0;
  localparam logic [1:0] KIND_IND  = 2'd1;
  localparam logic [1:0] KIND_MOVX = 2'd2;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_LO   = 3'd1,
    TGT_HI   = 3'd2,
    TGT_SFR  = 3'd3,
    TGT_XR   = 3'd4,
    TGT_EXT  = 3'd5
  } tgt_e;

  function automatic logic [NUM_TGT-1:0] tgt_onehot(input tgt_e t);
    case (t)
      TGT_LO:  return 5'b00001;
      TGT_HI:  return 5'b00010;
      TGT_SFR: return 5'b00100;
      TGT_XR:  return 5'b01000;
      TGT_EXT: return 5'b10000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LO_BYTES = 128,
  parameter int XR_BYTES = 768
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              extram_sel,
  output tgt_e              tgt
);
  logic above_lo;
  logic in_xr;

  assign above_lo = addr[7:0] >= 8'(LO_BYTES);
  assign in_xr    = addr < ADDR_W'(XR_BYTES);

  always_comb begin
    tgt = TGT_NONE;
    case (kind)
      KIND_DIR:  tgt = above_lo ? TGT_SFR : TGT_LO;
      KIND_IND:  tgt = above_lo ? TGT_HI  : TGT_LO;
      KIND_MOVX: tgt = (!extram_sel && in_xr) ? TGT_XR : TGT_EXT;
      default:   tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dmem_extif.sv
module dmem_extif #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic              ext_vld,
  output logic              ret_vld,
  output logic [DATA_W-1:0] ret_data
);
  logic pend;
  logic take;

  assign take = ext_vld & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_req <= 1'b0;
      pend    <= 1'b0;
      ret_vld <= 1'b0;
    end else begin
      ext_req <= go;
      ret_vld <= take;
      if (go && !we) pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      ext_we    <= we;
      ext_addr  <= addr;
      ext_wdata <= wdata;
    end
    if (take) ret_data <= ext_rdata;
  end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int LO_BYTES = 128,
  parameter int HI_BYTES = 128,
  parameter int XR_BYTES = 768
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         acc_kind,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               extram_sel,
  output logic [DATA_W-1:0]  rdata,
  output logic               rdata_vld,
  output logic [NUM_TGT-1:0] cs,
  output logic               sfr_rd,
  output logic               sfr_wr,
  output logic [7:0]         sfr_addr,
  output logic [DATA_W-1:0]  sfr_wdata,
  input  logic [DATA_W-1:0]  sfr_rdata,
  output logic               ext_req,
  output logic               ext_we,
  output logic [ADDR_W-1:0]  ext_addr,
  output logic [DATA_W-1:0]  ext_wdata,
  input  logic [DATA_W-1:0]  ext_rdata,
  input  logic               ext_vld
);
  localparam int LO_AW = $clog2(LO_BYTES);
  localparam int HI_AW = $clog2(HI_BYTES);
  localparam int XR_AW = $clog2(XR_BYTES);

  tgt_e tgt;
  tgt_e rsel_q;
  logic acc, is_wr, is_rd;
  logic lo_we, lo_re, hi_we, hi_re, xr_we, xr_re;
  logic int_vld_q;
  logic [NUM_TGT-1:0] cs_q;
  logic [DATA_W-1:0] lo_q, hi_q, xr_q, sfr_q, ret_data;
  logic ret_vld;
  logic [7:0] hi_off;

  assign acc   = rd_en | wr_en;
  assign is_wr = wr_en;
  assign is_rd = rd_en & ~wr_en;

  dmem_decode #(
    .ADDR_W(ADDR_W), .LO_BYTES(LO_BYTES), .XR_BYTES(XR_BYTES)
  ) u_dec (
    .kind(acc_kind), .addr(addr), .extram_sel(extram_sel), .tgt(tgt)
  );

  assign lo_we = is_wr & (tgt == TGT_LO);
  assign lo_re = is_rd & (tgt == TGT_LO);
  assign hi_we = is_wr & (tgt == TGT_HI);
  assign hi_re = is_rd & (tgt == TGT_HI);
  assign xr_we = is_wr & (tgt == TGT_XR);
  assign xr_re = is_rd & (tgt == TGT_XR);
  assign hi_off = addr[7:0] - 8'(LO_BYTES);

  dmem_ram #(.DEPTH(LO_BYTES), .DATA_W(DATA_W)) u_lo (
    .clk(clk), .we(lo_we), .re(lo_re), .addr(addr[LO_AW-1:0]),
    .wdata(wdata), .rdata(lo_q)
  );

  dmem_ram #(.DEPTH(HI_BYTES), .DATA_W(DATA_W)) u_hi (
    .clk(clk), .we(hi_we), .re(hi_re), .addr(hi_off[HI_AW-1:0]),
    .wdata(wdata), .rdata(hi_q)
  );

  dmem_ram #(.DEPTH(XR_BYTES), .DATA_W(DATA_W)) u_xr (
    .clk(clk), .we(xr_we), .re(xr_re), .addr(addr[XR_AW-1:0]),
    .wdata(wdata), .rdata(xr_q)
  );

  assign sfr_rd    = is_rd & (tgt == TGT_SFR);
  assign sfr_wr    = is_wr & (tgt == TGT_SFR);
  assign sfr_addr  = addr[7:0];
  assign sfr_wdata = wdata;

  dmem_extif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ext (
    .clk(clk), .rst(rst), .go(acc & (tgt == TGT_EXT)), .we(is_wr),
    .addr(addr), .wdata(wdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_vld(ext_vld),
    .ret_vld(ret_vld), .ret_data(ret_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_vld_q <= 1'b0;
      cs_q      <= '0;
      rsel_q    <= TGT_NONE;
    end else begin
      int_vld_q <= is_rd & (tgt inside {TGT_LO, TGT_HI, TGT_SFR, TGT_XR});
      cs_q      <= acc ? tgt_onehot(tgt) : '0;
      if (is_rd) rsel_q <= tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (sfr_rd) sfr_q <= sfr_rdata;
  end

  always_comb begin
    if (ret_vld) rdata = ret_data;
    else begin
      case (rsel_q)
        TGT_LO:  rdata = lo_q;
        TGT_HI:  rdata = hi_q;
        TGT_SFR: rdata = sfr_q;
        TGT_XR:  rdata = xr_q;
        default: rdata = '0;
      endcase
    end
  end

  assign rdata_vld = int_vld_q | ret_vld;
  assign cs        = cs_q;
endmodule

// File: rtl/dmem_router_chk.sv
module dmem_router_chk
  import dmem_router_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int XR_BYTES = 768
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         acc_kind,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd_en,
  input logic               wr_en,
  input logic               extram_sel,
  input logic [NUM_TGT-1:0] cs,
  input logic               sfr_rd,
  input logic               sfr_wr,
  input logic               ext_req,
  input logic               rdata_vld,
  input logic               hi_we
);
  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));

  // R8
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> (cs == '0));

  // R3
  sfr_sep_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd || sfr_wr) |-> (acc_kind == KIND_DIR && !hi_we));

  // R5
  ext_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && acc_kind == KIND_MOVX &&
     (extram_sel || addr >= ADDR_W'(XR_BYTES))) |=> ext_req);

  // R7
  int_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && (acc_kind == KIND_DIR || acc_kind == KIND_IND))
      |=> rdata_vld);
endmodule

bind dmem_router dmem_router_chk #(.ADDR_W(ADDR_W), .XR_BYTES(XR_BYTES)) u_chk (
  .clk(clk), .rst(rst), .acc_kind(acc_kind), .addr(addr), .rd_en(rd_en),
  .wr_en(wr_en), .extram_sel(extram_sel), .cs(cs), .sfr_rd(sfr_rd),
  .sfr_wr(sfr_wr), .ext_req(ext_req), .rdata_vld(rdata_vld), .hi_we(hi_we)
);

// File: tb/tb_dmem_router.sv
module tb_dmem_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_kind = 2'd0;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        extram_sel = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_vld;
  logic [4:0]  cs;
  logic        sfr_rd, sfr_wr;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = '0;
  logic        ext_vld = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;
  int sfr_wr_cnt = 0;
  logic [7:0] sfr_wr_addr, sfr_wr_data;

  always #10 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'h5A;

  always @(posedge clk) begin
    if (sfr_wr) begin
      sfr_wr_cnt++;
      sfr_wr_addr = sfr_addr;
      sfr_wr_data = sfr_wdata;
    end
  end

  dmem_router dut (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .extram_sel(extram_sel), .rdata(rdata),
    .rdata_vld(rdata_vld), .cs(cs), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_vld(ext_vld)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive one access for one cycle; returns after the capturing edge.
  task automatic acc(input logic [1:0] k, input logic [15:0] a, input logic r,
                     input logic w, input logic [7:0] d, input logic x);
    @(negedge clk);
    acc_kind = k; addr = a; rd_en = r; wr_en = w; wdata = d; extram_sel = x;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R10 rdata_vld", rdata_vld, 0);
    chk("R10 cs", cs, 0);
    chk("R10 ext_req", ext_req, 0);
    rst = 0;
  endtask

  task automatic t_lower();
    acc(2'd0, 16'h0011, 0, 1, 8'hA1, 0);
    chk("R1 cs lower", cs, 5'b00001);
    chk("R7 write no vld", rdata_vld, 0);
    acc(2'd1, 16'hFF11, 1, 0, 8'h00, 0);
    chk("R11 vld", rdata_vld, 1);
    chk("R1 R11 indirect sees direct", rdata, 8'hA1);
    acc(2'd1, 16'h007F, 0, 1, 8'h3C, 0);
    acc(2'd0, 16'h007F, 1, 0, 8'h00, 0);
    chk("R1 edge 7F", rdata, 8'h3C);
    chk("R1 cs 7F", cs, 5'b00001);
  endtask

  task automatic t_upper();
    acc(2'd1, 16'h0090, 0, 1, 8'h77, 0);
    chk("R2 cs upper", cs, 5'b00010);
    acc(2'd1, 16'h0080, 0, 1, 8'h11, 0);
    acc(2'd1, 16'h00FF, 0, 1, 8'hEE, 0);
    acc(2'd1, 16'h0090, 1, 0, 8'h00, 0);
    chk("R7 R2 read 90", rdata, 8'h77);
    chk("R7 vld upper", rdata_vld, 1);
    acc(2'd1, 16'h0080, 1, 0, 8'h00, 0);
    chk("R2 read 80", rdata, 8'h11);
    acc(2'd1, 16'h00FF, 1, 0, 8'h00, 0);
    chk("R2 read FF", rdata, 8'hEE);
  endtask

  task automatic t_sfr();
    int n0 = sfr_wr_cnt;
    acc(2'd0, 16'h0090, 0, 1, 8'h42, 0);
    chk("R3 cs sfr", cs, 5'b00100);
    chk("R3 sfr write seen", sfr_wr_cnt, n0 + 1);
    chk("R3 sfr addr", sfr_wr_addr, 8'h90);
    chk("R3 sfr data", sfr_wr_data, 8'h42);
    acc(2'd1, 16'h0090, 1, 0, 8'h00, 0);
    chk("R3 upper untouched", rdata, 8'h77);
    acc(2'd0, 16'h0090, 1, 0, 8'h00, 0);
    chk("R3 sfr read data", rdata, 8'hCA);
    chk("R3 sfr read vld", rdata_vld, 1);
  endtask

  task automatic t_xram();
    acc(2'd2, 16'h0011, 0, 1, 8'h5B, 0);
    chk("R4 cs xram", cs, 5'b01000);
    chk("R4 no ext req", ext_req, 0);
    acc(2'd2, 16'h0011, 1, 0, 8'h00, 0);
    chk("R4 xram read", rdata, 8'h5B);
    acc(2'd0, 16'h0011, 1, 0, 8'h00, 0);
    chk("R4 lower separate", rdata, 8'hA1);
    acc(2'd2, 16'h02FF, 0, 1, 8'h99, 0);
    acc(2'd2, 16'h02FF, 1, 0, 8'h00, 0);
    chk("R4 xram 2FF", rdata, 8'h99);
  endtask

  task automatic t_ext_wr();
    acc(2'd2, 16'h0300, 0, 1, 8'h66, 0);
    chk("R5 req", ext_req, 1);
    chk("R5 addr", ext_addr, 16'h0300);
    chk("R5 we", ext_we, 1);
    chk("R5 wdata", ext_wdata, 8'h66);
    chk("R5 cs ext", cs, 5'b10000);
    @(negedge clk);
    chk("R5 req one cycle", ext_req, 0);
    acc(2'd2, 16'h0011, 0, 1, 8'h12, 1);
    chk("R5 extram_sel req", ext_req, 1);
    chk("R5 extram_sel addr", ext_addr, 16'h0011);
    acc(2'd2, 16'h0011, 1, 0, 8'h00, 0);
    chk("R5 xram untouched", rdata, 8'h5B);
  endtask

  task automatic t_ext_rd();
    acc(2'd2, 16'h1234, 1, 0, 8'h00, 0);
    chk("R6 req", ext_req, 1);
    chk("R6 we", ext_we, 0);
    chk("R6 addr", ext_addr, 16'h1234);
    chk("R6 no early vld", rdata_vld, 0);
    @(negedge clk);
    chk("R6 wait vld", rdata_vld, 0);
    ext_vld = 1; ext_rdata = 8'hC3;
    @(negedge clk);
    ext_vld = 0;
    chk("R6 vld", rdata_vld, 1);
    chk("R6 data", rdata, 8'hC3);
    @(negedge clk);
    chk("R6 vld drops", rdata_vld, 0);
    ext_vld = 1; ext_rdata = 8'hAA;
    @(negedge clk);
    ext_vld = 0;
    chk("R6 stray vld ignored", rdata_vld, 0);
  endtask

  task automatic t_both();
    acc(2'd1, 16'h0020, 1, 1, 8'h4D, 0);
    chk("R9 no read vld", rdata_vld, 0);
    acc(2'd1, 16'h0020, 1, 0, 8'h00, 0);
    chk("R9 write taken", rdata, 8'h4D);
  endtask

  task automatic t_reserved();
    acc(2'd0, 16'h0010, 0, 1, 8'h01, 0);
    acc(2'd3, 16'h0010, 0, 1, 8'hFF, 0);
    chk("R8 reserved cs", cs, 5'b00000);
    chk("R8 reserved no ext", ext_req, 0);
    acc(2'd0, 16'h0010, 1, 0, 8'h00, 0);
    chk("R8 reserved no write", rdata, 8'h01);
    @(negedge clk);
    chk("R8 idle cs", cs, 5'b00000);
  endtask

  initial begin
    t_reset();
    t_lower();
    t_upper();
    t_sfr();
    t_xram();
    t_ext_wr();
    t_ext_rd();
    t_both();
    t_reserved();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule